// File: doc/BRIEF.md
# Low-Side PWM Gate Generator with Peak Current Cutoff

This block drives the low-side gate of a three-phase motor bridge that uses direct PWM. A free-running counter forms a digital ramp and sets the switching period at 2^CNT_W clock cycles. The gate is on only when two conditions hold. The first is an active-low pulse input that says the switch may conduct. The second is a compare of the ramp against a threshold word. The compare is inverted, so a smaller threshold gives a wider on-time. A threshold of zero leaves the pulse input fully in control.

A peak current-limit input is synchronized first. When it trips, the gate is held off for the rest of the current period. Switching resumes at the next period boundary. The block also produces a one-cycle tick at every period start, which other control logic uses as its time base. A zero-duty flag reports whether the period that just ended had no on-time at all.

Top module: `pwm_duty_gen`

## Requirements
- R1: The ramp counts freely through 2^CNT_W values regardless of any input. `periodTick` is high for exactly one cycle, the one in which the ramp is zero, at every period start except the first period after reset. It is never high in two consecutive cycles.
- R2: While `pulseInN` is high, `gateOn` is low in that same cycle, because the pulse input reaches the gate with no register in between. An undriven pin is pulled high outside the block, which keeps the gate off.
- R3: While `pulseInN` is low and no trip is active, `gateOn` is high in exactly the cycles where ramp >= `threshold`. This gives 2^CNT_W − `threshold` on-cycles per period, so a threshold of 0 keeps the gate on for the whole period.
- R4: `currentLimit` passes through SYNC_STAGES flops (default 2). A trip takes effect SYNC_STAGES+1 rising edges after the input is first sampled high. From then on, `gateOn` stays low to the end of the period.
- R5: A trip clears at the start of the next period, and only there. If the limit is no longer active, the gate is on again from the first cycle of that period.
- R6: If the synchronized limit is still high at a period boundary, the trip is kept and the gate stays off for the whole following period.
- R7: At each period start, `zeroDuty` takes the value 1 if `gateOn` was never high in the period that just ended, and 0 otherwise. It changes at no other time.
- R8: During and right after reset, the ramp is 0, no trip is active, and `periodTick` and `zeroDuty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulseInN | input | 1 | External drive pulse; low allows conduction |
| threshold | input | CNT_W | Compare level; lower value gives more on-time |
| currentLimit | input | 1 | Asynchronous peak current trip request |
| gateOn | output | 1 | Low-side gate enable |
| periodTick | output | 1 | One-cycle pulse at each period start |
| zeroDuty | output | 1 | High when the previous period had no on-time |

## Verification
The hardest situation to reach is a trip that lasts through a period boundary. To get there, the limit must be raised late in one period and held until the wrap, so that the synchronizer is still high when the clear would normally happen. The bench holds the limit across the boundary and then releases it at the first cycle of the next period. That checks three things: the trip set wins over the clear, the period that follows stays fully off and raises `zeroDuty`, and the gate returns only one boundary after that. A separate period shows the exact cutoff cycle for a short trip pulse, counted from the synchronizer depth.

// File: rtl/pwm_duty_pkg.sv
package pwm_duty_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic tripped;
    logic periodStart;
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic rampAtMax;
    logic limitSync;
    logic gateOn;
  } dpStatus_t;

endpackage

// File: rtl/pwm_duty_datapath.sv
module pwm_duty_datapath
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulseInN,
  input  logic [CNT_W-1:0] threshold,
  input  logic             currentLimit,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic             gateOn
);

  localparam logic [CNT_W-1:0] RAMP_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RAMP_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0]       ramp;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   compareOk;
  logic                   pulseAllows;

  // Free-running ramp; wraps without any input influence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ramp <= '0;
    else        ramp <= ramp + RAMP_ONE;
  end

  // Synchronizer chain for the asynchronous limit request
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[0] <= 1'b0;
          else        syncQ[0] <= currentLimit;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) syncQ[g] <= 1'b0;
          else        syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  // Inverted compare: lower threshold opens the window earlier
  assign compareOk   = (ramp >= threshold);
  assign pulseAllows = ~pulseInN;
  assign gateOn      = pulseAllows & compareOk & ~strobe.tripped;

  assign status.rampAtMax = (ramp == RAMP_MAX);
  assign status.limitSync = syncQ[SYNC_STAGES-1];
  assign status.gateOn    = gateOn;

endmodule

// File: rtl/pwm_duty_control.sv
module pwm_duty_control
  import pwm_duty_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        periodTick,
  output logic        zeroDuty
);

  logic tickQ;
  logic tripQ;
  logic anyOnQ;
  logic zeroDutyQ;

  // Tick lands in the cycle where the ramp reads zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tickQ <= 1'b0;
    else        tickQ <= status.rampAtMax;
  end

  // Trip latch: a set beats the period-boundary clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tripQ <= 1'b0;
    else if (status.limitSync) tripQ <= 1'b1;
    else if (status.rampAtMax) tripQ <= 1'b0;
  end

  // On-time seen in the running period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                anyOnQ <= 1'b0;
    else if (status.rampAtMax) anyOnQ <= 1'b0;
    else if (status.gateOn)    anyOnQ <= 1'b1;
  end

  // Flag for the period that just closed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                zeroDutyQ <= 1'b0;
    else if (status.rampAtMax) zeroDutyQ <= ~(anyOnQ | status.gateOn);
  end

  assign strobe.tripped     = tripQ;
  assign strobe.periodStart = tickQ;
  assign periodTick         = tickQ;
  assign zeroDuty           = zeroDutyQ;

endmodule

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen
  import pwm_duty_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulseInN,
  input  logic [CNT_W-1:0] threshold,
  input  logic             currentLimit,
  output logic             gateOn,
  output logic             periodTick,
  output logic             zeroDuty
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        tripped;

  pwm_duty_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk          (clk),
    .rst_n        (rst_n),
    .pulseInN     (pulseInN),
    .threshold    (threshold),
    .currentLimit (currentLimit),
    .strobe       (strobe),
    .status       (status),
    .gateOn       (gateOn)
  );

  pwm_duty_control i_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (status),
    .strobe     (strobe),
    .periodTick (periodTick),
    .zeroDuty   (zeroDuty)
  );

  assign tripped = strobe.tripped;

endmodule

// File: rtl/pwm_duty_checker.sv
module pwm_duty_checker (
  input logic clk,
  input logic rst_n,
  input logic pulseInN,
  input logic gateOn,
  input logic periodTick,
  input logic zeroDuty,
  input logic tripped
);

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    periodTick |=> !periodTick);

  assert_pulse_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulseInN |-> !gateOn);

  assert_trip_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tripped |-> !gateOn);

  assert_trip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tripped) |-> periodTick);

  assert_flag_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zeroDuty) |-> periodTick);

endmodule

bind pwm_duty_gen pwm_duty_checker i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pulseInN   (pulseInN),
  .gateOn     (gateOn),
  .periodTick (periodTick),
  .zeroDuty   (zeroDuty),
  .tripped    (tripped)
);

// File: tb/test_pwm_duty_gen.sv
module test_pwm_duty_gen;

  localparam int W      = 4;
  localparam int PERIOD = 1 << W;
  localparam int NVEC   = 6;
  // columns: pulseInN, threshold, expected on-cycles
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 16}, '{0, 5, 11}, '{0, 10, 6},
    '{0, 15, 1}, '{1, 0, 0},  '{1, 7, 0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pulseInN;
  logic [W-1:0] threshold;
  logic         currentLimit;
  logic         gateOn, periodTick, zeroDuty;
  int           nChecks = 0;
  int           nFails  = 0;

  always #2 clk = ~clk;

  pwm_duty_gen #(.CNT_W(W)) i_pwm_duty_gen (
    .clk(clk), .rst_n(rst_n), .pulseInN(pulseInN), .threshold(threshold),
    .currentLimit(currentLimit), .gateOn(gateOn), .periodTick(periodTick),
    .zeroDuty(zeroDuty)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic alignStart();
    do begin @(negedge clk); #1; end while (!periodTick);
  endtask

  // Runs one period from its ramp-zero cycle; ends at the next ramp-zero cycle
  task automatic runPeriod(input logic pN, input int thr, input int limAt,
                           input bit limHold, output int onCnt,
                           output int tickCnt, output int zd);
    onCnt = 0; tickCnt = 0;
    for (int i = 0; i < PERIOD; i++) begin
      if (i > 0) @(negedge clk);
      pulseInN  = pN;
      threshold = W'(thr);
      if (i == limAt)    currentLimit = 1'b1;
      else if (!limHold) currentLimit = 1'b0;
      #1;
      onCnt   += int'(gateOn);
      tickCnt += int'(periodTick);
    end
    @(negedge clk); #1;
    zd = int'(zeroDuty);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int onCnt, tickCnt, zd;
    rst_n = 1'b0; pulseInN = 1'b1; threshold = '0; currentLimit = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R8 gate in reset", int'(gateOn), 0);
    check("R8 tick in reset", int'(periodTick), 0);
    check("R8 zeroDuty in reset", int'(zeroDuty), 0);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R8 no tick in first period", int'(periodTick), 0);

    alignStart();
    for (int v = 0; v < NVEC; v++) begin
      runPeriod(VEC[v][0] != 0, VEC[v][1], -1, 1'b0, onCnt, tickCnt, zd);
      check($sformatf("R3 on-cycles vec%0d", v), onCnt, VEC[v][2]);
      check($sformatf("R1 tick count vec%0d", v), tickCnt, 1);
      check($sformatf("R7 zeroDuty vec%0d", v), zd, int'(VEC[v][2] == 0));
    end

    // R4: one-cycle limit pulse at ramp 4 -> off from ramp 7
    runPeriod(1'b0, 0, 4, 1'b0, onCnt, tickCnt, zd);
    check("R4 cutoff after short trip", onCnt, 7);
    check("R7 zeroDuty after partial", zd, 0);
    // R5: next period fully on again
    runPeriod(1'b0, 0, -1, 1'b0, onCnt, tickCnt, zd);
    check("R5 resume at boundary", onCnt, PERIOD);
    check("R7 zeroDuty full period", zd, 0);
    // R6: limit raised at ramp 10 and held across the boundary
    runPeriod(1'b0, 0, 10, 1'b1, onCnt, tickCnt, zd);
    check("R4 cutoff held trip", onCnt, 13);
    check("R7 zeroDuty held trip", zd, 0);
    runPeriod(1'b0, 0, -1, 1'b1, onCnt, tickCnt, zd);
    check("R6 trip kept over boundary", onCnt, 0);
    check("R7 zeroDuty blocked period", zd, 1);
    // released at ramp 0: trip still stands until the next boundary
    runPeriod(1'b0, 0, -1, 1'b0, onCnt, tickCnt, zd);
    check("R5 no mid-period clear", onCnt, 0);
    check("R7 zeroDuty still blocked", zd, 1);
    runPeriod(1'b0, 0, -1, 1'b0, onCnt, tickCnt, zd);
    check("R5 resume after release", onCnt, PERIOD);
    check("R7 zeroDuty cleared", zd, 0);

    // R2: pulse reaches the gate within the same cycle
    repeat (3) @(negedge clk);
    pulseInN = 1'b1; #1;
    check("R2 pulse high blocks gate", int'(gateOn), 0);
    pulseInN = 1'b0; #1;
    check("R2 pulse low passes through", int'(gateOn), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule